// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Miss Refill

This block sits between a processor's fetch stage and a slow main-memory read port. Each line holds one 32-bit instruction word, its tag and a valid bit. Every memory word maps to exactly one line. The line number is the word address taken modulo the number of lines, so one lookup checks a single location. A hit returns the instruction combinationally in the same cycle.

The fetch stage drives a program counter that has already been advanced past the instruction it wants. The cache therefore looks up, and fetches from memory, the address `fetch_pc - 4`. On a miss it raises `fetch_stall` at once and sends that word-aligned address to memory. It then waits for the memory for as many cycles as the memory takes. Next it writes the returned word, the tag and a set valid bit into the line. It then returns to lookup, so the held fetch is replayed and hits.

All valid bits are cleared by a synchronous reset, in one cycle. Stale tags therefore never match after start-up. Stores, multi-word lines and associativity are not part of this block.

Top module: `icache_dm`

## Requirements
- R1: Line index is lookup-address bits [11:2] (word address modulo 1024) and the stored tag is bits [31:12]; neighbouring words use separate lines.
- R2: The lookup address is `fetch_pc - 4` (wrapping modulo 2^32); its bits [1:0] are ignored, so any byte of a cached word hits.
- R3: With `fetch_en` high in the lookup state, `fetch_hit` is high and `fetch_stall` low in the same cycle exactly when the indexed line is valid and its tag equals bits [31:12]; `fetch_instr` then carries the stored word.
- R4: Reset (synchronous, active high) clears every valid bit, so the first fetch of any address after reset misses.
- R5: A miss raises `fetch_stall` in the same cycle, and it stays high every cycle until the replayed fetch hits. With a memory that answers L cycles after seeing the request, the hit comes 3+L cycles after the miss cycle.
- R6: The cycle after a miss, `mem_req` goes high with `mem_addr` equal to the lookup address with bits [1:0] forced to 0. Both hold steady until `mem_ack`, and `mem_req` drops the cycle after it.
- R7: The controller waits for any memory latency. A `mem_ack` that arrives while no request is outstanding changes no line.
- R8: On refill, `mem_rdata` becomes the line's data, the upper address bits become its tag, and its valid bit is set. The replayed fetch hits with that word, and no further memory request is made.
- R9: Two addresses with the same index and different tags evict each other, so refetching the first after the second misses again.
- R10: While the controller is waiting on memory or refilling, no fetch is accepted: `fetch_hit` stays low and `fetch_stall` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_en | input | 1 | Fetch stage requests an instruction |
| fetch_pc | input | 32 | Already-advanced program counter; held while stalled |
| fetch_hit | output | 1 | Instruction on `fetch_instr` is valid this cycle |
| fetch_instr | output | 32 | Instruction word read from the indexed line |
| fetch_stall | output | 1 | Freeze fetch: miss detected or refill in progress |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 32 | Word-aligned byte address of the missing instruction |
| mem_ack | input | 1 | Memory read complete, `mem_rdata` valid |
| mem_rdata | input | 32 | Word returned by memory |

## Verification
The assertions check, on every cycle, the properties of the memory handshake. A request exists only while waiting, and it holds with a stable address until acknowledged. They also check that a lookup-state acknowledge never leads to a refill, that a hit never stalls, that reset leaves no valid bit set, and that the cycle after a refill a held fetch hits. Only the bench scenarios can show the values involved. These are that the data delivered is the word memory returned, and that the address sent is the advanced PC minus four. They also cover the stall length for a given latency, the index and tag split, conflict eviction, the offset bits being ignored, and the wrap at address zero.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_MEM_WAIT = 2'd1,
    ST_REFILL   = 2'd2
  } ic_state_e;
endpackage

// File: rtl/ic_valid_bits.sv
module ic_valid_bits #(
  parameter int LINES = 1024,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid
);
  logic [LINES-1:0] vbits_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vbits_q <= '0;
    end else if (set_en) begin
      vbits_q[set_idx] <= 1'b1;
    end
  end

  assign rd_valid = vbits_q[rd_idx];

  // R4: the cycle after reset no line is valid
  a_r4_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (vbits_q == '0));
endmodule

// File: rtl/ic_line_store.sv
module ic_line_store #(
  parameter int LINES  = 1024,
  parameter int IDX_W  = $clog2(LINES),
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data
);
  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [DATA_W-1:0] data_mem [LINES];

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
  end

  assign rd_tag  = tag_mem[rd_idx];
  assign rd_data = data_mem[rd_idx];
endmodule

// File: rtl/ic_ctrl.sv
module ic_ctrl
  import icache_pkg::*;
#(
  parameter int WADDR_W = 30,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fetch_en,
  input  logic               lookup_hit,
  input  logic [WADDR_W-1:0] lookup_waddr,
  input  logic               mem_ack,
  input  logic [DATA_W-1:0]  mem_rdata,
  output ic_state_e          state,
  output logic               mem_req,
  output logic [WADDR_W-1:0] miss_waddr,
  output logic               fill_we,
  output logic [DATA_W-1:0]  fill_data
);
  ic_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      mem_req    <= 1'b0;
      miss_waddr <= '0;
      fill_data  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (fetch_en && !lookup_hit) begin
            state_q    <= ST_MEM_WAIT;
            mem_req    <= 1'b1;
            miss_waddr <= lookup_waddr;
          end
        end
        ST_MEM_WAIT: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            fill_data <= mem_rdata;
            state_q   <= ST_REFILL;
          end
        end
        ST_REFILL: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign state   = state_q;
  assign fill_we = (state_q == ST_REFILL);

  // R6: a request exists only while waiting on memory
  a_r6_req_in_wait: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (state_q == ST_MEM_WAIT));
  // R6: request and address hold until acknowledged
  a_r6_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(miss_waddr)));
  // R7: an acknowledge seen in lookup never starts a refill
  a_r7_idle_ack_no_fill: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |=> (state_q != ST_REFILL));
endmodule

// File: rtl/icache_dm.sv
module icache_dm
  import icache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_en,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              fetch_hit,
  output logic [DATA_W-1:0] fetch_instr,
  output logic              fetch_stall,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int OFF_W   = $clog2(DATA_W / 8);
  localparam int IDX_W   = $clog2(LINES);
  localparam int WADDR_W = ADDR_W - OFF_W;
  localparam int TAG_W   = WADDR_W - IDX_W;

  // Subtracting one word from the PC leaves the byte-offset bits untouched.
  logic [WADDR_W-1:0] look_waddr;
  logic               unused_pc_off;
  assign look_waddr    = fetch_pc[ADDR_W-1:OFF_W] - WADDR_W'(1);
  assign unused_pc_off = ^fetch_pc[OFF_W-1:0];

  logic [IDX_W-1:0] look_idx;
  logic [TAG_W-1:0] look_tag;
  assign look_idx = look_waddr[IDX_W-1:0];
  assign look_tag = look_waddr[WADDR_W-1:IDX_W];

  ic_state_e          state;
  logic [WADDR_W-1:0] miss_waddr;
  logic               fill_we;
  logic [DATA_W-1:0]  fill_data;
  logic               line_valid;
  logic [TAG_W-1:0]   line_tag;
  logic               tag_match;
  logic               is_idle;

  ic_valid_bits #(.LINES(LINES), .IDX_W(IDX_W)) u_valid (
    .clk      (clk),
    .rst      (rst),
    .set_en   (fill_we),
    .set_idx  (miss_waddr[IDX_W-1:0]),
    .rd_idx   (look_idx),
    .rd_valid (line_valid)
  );

  ic_line_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .we      (fill_we),
    .wr_idx  (miss_waddr[IDX_W-1:0]),
    .wr_tag  (miss_waddr[WADDR_W-1:IDX_W]),
    .wr_data (fill_data),
    .rd_idx  (look_idx),
    .rd_tag  (line_tag),
    .rd_data (fetch_instr)
  );

  assign tag_match = line_valid && (line_tag == look_tag);

  ic_ctrl #(.WADDR_W(WADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .fetch_en     (fetch_en),
    .lookup_hit   (tag_match),
    .lookup_waddr (look_waddr),
    .mem_ack      (mem_ack),
    .mem_rdata    (mem_rdata),
    .state        (state),
    .mem_req      (mem_req),
    .miss_waddr   (miss_waddr),
    .fill_we      (fill_we),
    .fill_data    (fill_data)
  );

  assign is_idle     = (state == ST_IDLE);
  assign fetch_hit   = fetch_en && is_idle && tag_match;
  assign fetch_stall = !is_idle || (fetch_en && !tag_match);
  assign mem_addr    = {miss_waddr, {OFF_W{1'b0}}};

  // R3: a delivered instruction never comes with a stall
  a_r3_hit_no_stall: assert property (@(posedge clk) disable iff (rst)
    fetch_hit |-> !fetch_stall);
  // R10: nothing is accepted while busy
  a_r10_busy_no_hit: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> (!fetch_hit && fetch_stall));
  // R8: the held fetch hits right after the refill
  a_r8_replay_hits: assert property (@(posedge clk) disable iff (rst)
    ($past(state == ST_REFILL) && fetch_en && $stable(fetch_pc)) |-> fetch_hit);
endmodule

// File: tb/sim_icache_dm.sv
`timescale 1ns/1ps
module sim_icache_dm;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_en = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        fetch_hit;
  logic [31:0] fetch_instr;
  logic        fetch_stall;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  int lat = 0;
  int cnt = 0;
  int req_cnt = 0;
  logic spur = 1'b0;
  logic [31:0] last_req_addr = '0;

  always #2 clk = ~clk;

  icache_dm u0 (
    .clk(clk), .rst(rst), .fetch_en(fetch_en), .fetch_pc(fetch_pc),
    .fetch_hit(fetch_hit), .fetch_instr(fetch_instr), .fetch_stall(fetch_stall),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] mw(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A3C_0F96;
  endfunction

  // memory model: answers lat cycles after it first sees a request
  always @(negedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      cnt     <= 0;
    end else if (spur) begin
      mem_ack   <= 1'b1;
      mem_rdata <= 32'hDEAD_BEEF;
    end else if (mem_req && !mem_ack) begin
      if (cnt >= lat) begin
        mem_ack       <= 1'b1;
        mem_rdata     <= mw(mem_addr);
        last_req_addr <= mem_addr;
        req_cnt       <= req_cnt + 1;
        cnt           <= 0;
      end else begin
        cnt <= cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one fetch; exp_miss says whether a refill is expected
  task automatic do_fetch(input logic [31:0] pc, input bit exp_miss, input string req);
    logic [31:0] la;
    int n;
    int r0;
    bit busy_bad;
    la = (pc - 32'd4) & 32'hFFFF_FFFC;
    r0 = req_cnt;
    @(negedge clk);
    fetch_en = 1'b1;
    fetch_pc = pc;
    #1;
    if (exp_miss) begin
      chk(fetch_stall && !fetch_hit, req, "miss raises stall at once", {30'd0, fetch_stall, fetch_hit}, 32'h2);
      n = 0;
      busy_bad = 1'b0;
      while (!fetch_hit && n < 60) begin
        if (!fetch_stall) busy_bad = 1'b1;
        @(negedge clk);
        #1;
        n++;
      end
      chk(!busy_bad, "R10", "stall held, no hit while busy", {31'd0, busy_bad}, 32'd0);
      chk(n == lat + 3, "R5", "stall length", n, lat + 3);
      chk(last_req_addr == la, "R6", "memory address", last_req_addr, la);
      chk(req_cnt == r0 + 1, "R6", "one request per miss", req_cnt, r0 + 1);
      chk(fetch_instr == mw(la), "R8", "refilled word", fetch_instr, mw(la));
    end else begin
      chk(fetch_hit && !fetch_stall, req, "hit without stall", {30'd0, fetch_hit, fetch_stall}, 32'h2);
      chk(fetch_instr == mw(la), req, "hit data", fetch_instr, mw(la));
      @(negedge clk);
      #1;
      chk(req_cnt == r0 && !mem_req, req, "no memory traffic on hit", req_cnt, r0);
    end
    @(negedge clk);
    fetch_en = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!fetch_stall && !fetch_hit && !mem_req, "R4", "idle after reset",
        {29'd0, fetch_stall, fetch_hit, mem_req}, 32'd0);
  endtask

  task automatic t_cold_and_replay();
    lat = 2;
    do_fetch(32'h0000_0104, 1'b1, "R4");
    do_fetch(32'h0000_0104, 1'b0, "R3");
  endtask

  task automatic t_latencies();
    lat = 0;
    do_fetch(32'h0000_2208, 1'b1, "R7");
    lat = 7;
    do_fetch(32'h0004_0010, 1'b1, "R7");
    do_fetch(32'h0000_2208, 1'b0, "R7");
    do_fetch(32'h0004_0010, 1'b0, "R7");
  endtask

  task automatic t_offset_ignored();
    do_fetch(32'h0000_0106, 1'b0, "R2");
    do_fetch(32'h0000_0107, 1'b0, "R2");
  endtask

  task automatic t_index_split();
    lat = 1;
    do_fetch(32'h0000_0108, 1'b1, "R1");
    do_fetch(32'h0000_0104, 1'b0, "R1");
    do_fetch(32'h0000_0108, 1'b0, "R1");
  endtask

  task automatic t_conflict();
    lat = 3;
    do_fetch(32'h0000_1104, 1'b1, "R9");
    do_fetch(32'h0000_0104, 1'b1, "R9");
    do_fetch(32'h0000_1104, 1'b1, "R9");
    do_fetch(32'h0000_0108, 1'b0, "R9");
  endtask

  task automatic t_spurious_ack();
    @(posedge clk);
    spur = 1'b1;
    @(posedge clk);
    spur = 1'b0;
    repeat (3) @(posedge clk);
    do_fetch(32'h0000_1104, 1'b0, "R7");
    lat = 0;
    do_fetch(32'h0000_3004, 1'b1, "R7");
  endtask

  task automatic t_wrap();
    lat = 4;
    do_fetch(32'h0000_0000, 1'b1, "R2");
    do_fetch(32'h0000_0000, 1'b0, "R2");
  endtask

  task automatic t_reset_again();
    t_reset();
    lat = 1;
    do_fetch(32'h0000_0108, 1'b1, "R4");
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_cold_and_replay();
    t_latencies();
    t_offset_ignored();
    t_index_split();
    t_conflict();
    t_spurious_ack();
    t_wrap();
    t_reset_again();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule